// File: doc/BRIEF.md
# Hyperprivileged Control Register File

This block holds the small set of control registers that belong to the most privileged execution level of a processor strand: a hyper processor-state word, a hyper interrupt-pending word, a hyper trap-state word, a hyper trap base address, a read-only version word and a strand status word. An access presents a register index with a read or a write strobe. The block decodes the index and checks the access against the current trap level. It either performs the access or reports an illegal-instruction fault.

Reads are answered in the same cycle as the strobe. The read data and the fault code come out of combinational decode and a select tree, and all of it is backed by registered state. Writes take effect at the next rising clock edge.

The trap base register keeps only its upper bits, so its low 15 bits are always zero. The version word is built from three configuration inputs. The strand status word follows a status input from outside the block and cannot be written.

Top module: `hpriv_ctl_regs`

## Requirements
- R1: A synchronous active-high reset clears every writable register to zero. After reset, the strand status register holds the value of `sts_in` sampled at the reset edge.
- R2: The processor-state register (index 0) and the interrupt-pending register (index 1) return on a read the last value written to them. They hold that value while other registers are accessed.
- R3: The trap base register (index 3) discards bits [14:0] on a write. A read of it always returns bits [14:0] as zero and the written upper bits unchanged.
- R4: The trap-state register (index 2) is readable and writable while `trap_lvl` is nonzero. Any access to it while `trap_lvl` equals 0 raises fault code 1 (illegal) and returns zero data, and a write made then leaves the register unchanged.
- R5: The version register (index 4) reads as `cfg_nwin` in bits [7:0], `cfg_maxtl` in bits [15:8] and `cfg_maxgl` in bits [23:16], with all higher bits zero. A write to it raises fault code 1.
- R6: A write to the strand status register (index 5) raises no fault and is ignored. A read of it returns `sts_in` as sampled at the previous rising clock edge.
- R7: An access to any index of 6 or above raises fault code 1 and returns zero data, and it changes no register.
- R8: `fault` is 0 (none) or 1 (illegal) and is valid in the same cycle as the strobe. `rd_data` is zero whenever no read strobe is present or the read faults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_idx | input | 5 | Register index |
| acc_wdata | input | 64 | Write data |
| trap_lvl | input | 3 | Current trap level |
| cfg_nwin | input | 8 | Window count for the version word |
| cfg_maxtl | input | 8 | Maximum trap level for the version word |
| cfg_maxgl | input | 8 | Maximum global level for the version word |
| sts_in | input | 64 | Externally supplied strand status |
| rd_data | output | 64 | Read data, same cycle as `acc_rd` |
| fault | output | 2 | Fault code: 0 none, 1 illegal instruction |

## Verification
The assertions assume that the read and write strobes are never raised together. They also assume that `sts_in` and the configuration inputs carry known values from the first clock edge, because the strand status check compares a read against the previous cycle's `sts_in`. The stimulus drives exactly one strobe, or none, in each cycle and changes inputs only at falling edges. It holds `sts_in` and the configuration constant through the vector table, then changes them in directed steps so that the one-cycle lag of the status register and the combinational version word are both observed.

// File: rtl/hpr_pkg.sv
package hpr_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_ILLEGAL = 2'd1
  } fault_e;

  localparam int NREG   = 6;
  localparam int NPLAIN = 3;   // indices 0..NPLAIN-1 are plain read/write
  localparam int R_HPST = 0;
  localparam int R_HINT = 1;
  localparam int R_HTST = 2;
  localparam int R_HTBA = 3;
  localparam int R_HVER = 4;
  localparam int R_STS  = 5;
endpackage

// File: rtl/hpr_decode.sv
module hpr_decode
  import hpr_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int TL_W  = 3
) (
  input  logic             rd,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [TL_W-1:0]  trap_lvl,
  output logic [NREG-1:0]  rsel,
  output logic [NREG-1:0]  we,
  output fault_e           fault_o
);
  logic known;
  logic tl_bad;
  logic ro_hit;
  logic rd_bad;
  logic wr_bad;

  always_comb begin
    known  = (idx < IDX_W'(NREG));
    tl_bad = (idx == IDX_W'(R_HTST)) && (trap_lvl == '0);
    ro_hit = (idx == IDX_W'(R_HVER));
    rd_bad = rd && (!known || tl_bad);
    wr_bad = wr && (!known || tl_bad || ro_hit);
    fault_o = (rd_bad || wr_bad) ? FLT_ILLEGAL : FLT_NONE;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    logic hit;
    assign hit     = (idx == IDX_W'(i));
    assign rsel[i] = rd && hit && !rd_bad;
    assign we[i]   = wr && hit && !wr_bad;
  end

  // R8: at most one register is selected for read or write per access
  always_comb begin
    p_onehot_sel_r8: assert ($onehot0(rsel) && $onehot0(we));
  end
endmodule

// File: rtl/hpr_store.sv
module hpr_store
  import hpr_pkg::*;
#(
  parameter int DW   = 64,
  parameter int LOWZ = 15
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NREG-1:0]             we,
  input  logic [DW-1:0]               wdata,
  input  logic [DW-1:0]               sts_in,
  output logic [NPLAIN-1:0][DW-1:0]   plain_q,
  output logic [DW-1:0]               htba_q,
  output logic [DW-1:0]               sts_q
);
  localparam int HI_W = DW - LOWZ;

  logic [HI_W-1:0] htba_hi;

  for (genvar i = 0; i < NPLAIN; i++) begin : g_plain
    always_ff @(posedge clk) begin
      if (rst)        plain_q[i] <= '0;
      else if (we[i]) plain_q[i] <= wdata;
    end

    // R2 R4: a plain register moves only on its own accepted write
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !we[i] |=> $stable(plain_q[i]));
  end

  always_ff @(posedge clk) begin
    if (rst)             htba_hi <= '0;
    else if (we[R_HTBA]) htba_hi <= wdata[DW-1:LOWZ];
  end
  assign htba_q = {htba_hi, {LOWZ{1'b0}}};

  // Status follows its input every cycle; writes never reach it.
  always_ff @(posedge clk) begin
    sts_q <= sts_in;
  end

  // R6: status register always carries the previous cycle's input
  p_sts_follow_r6: assert property (@(posedge clk) disable iff (rst)
    we[R_STS] |=> sts_q == $past(sts_in));
endmodule

// File: rtl/hpr_rdmux.sv
module hpr_rdmux
  import hpr_pkg::*;
#(
  parameter int DW    = 64,
  parameter int FLD_W = 8
) (
  input  logic [NREG-1:0]           rsel,
  input  logic [NPLAIN-1:0][DW-1:0] plain_q,
  input  logic [DW-1:0]             htba_q,
  input  logic [DW-1:0]             sts_q,
  input  logic [FLD_W-1:0]          cfg_nwin,
  input  logic [FLD_W-1:0]          cfg_maxtl,
  input  logic [FLD_W-1:0]          cfg_maxgl,
  output logic [DW-1:0]             rd_data
);
  localparam int VER_W = 3 * FLD_W;

  logic [NREG-1:0][DW-1:0] src;

  for (genvar i = 0; i < NPLAIN; i++) begin : g_src
    assign src[i] = plain_q[i];
  end
  assign src[R_HTBA] = htba_q;
  assign src[R_HVER] = {{(DW-VER_W){1'b0}}, cfg_maxgl, cfg_maxtl, cfg_nwin};
  assign src[R_STS]  = sts_q;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      rd_data = rd_data | (src[i] & {DW{rsel[i]}});
    end
  end
endmodule

// File: rtl/hpriv_ctl_regs.sv
module hpriv_ctl_regs
  import hpr_pkg::*;
#(
  parameter int DW    = 64,
  parameter int IDX_W = 5,
  parameter int TL_W  = 3,
  parameter int FLD_W = 8,
  parameter int LOWZ  = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_rd,
  input  logic             acc_wr,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [DW-1:0]    acc_wdata,
  input  logic [TL_W-1:0]  trap_lvl,
  input  logic [FLD_W-1:0] cfg_nwin,
  input  logic [FLD_W-1:0] cfg_maxtl,
  input  logic [FLD_W-1:0] cfg_maxgl,
  input  logic [DW-1:0]    sts_in,
  output logic [DW-1:0]    rd_data,
  output logic [1:0]       fault
);
  logic [NREG-1:0]           rsel;
  logic [NREG-1:0]           we;
  fault_e                    flt;
  logic [NPLAIN-1:0][DW-1:0] plain_q;
  logic [DW-1:0]             htba_q;
  logic [DW-1:0]             sts_q;

  hpr_decode #(.IDX_W(IDX_W), .TL_W(TL_W)) u_decode (
    .rd(acc_rd), .wr(acc_wr), .idx(acc_idx), .trap_lvl(trap_lvl),
    .rsel(rsel), .we(we), .fault_o(flt)
  );

  hpr_store #(.DW(DW), .LOWZ(LOWZ)) u_store (
    .clk(clk), .rst(rst), .we(we), .wdata(acc_wdata), .sts_in(sts_in),
    .plain_q(plain_q), .htba_q(htba_q), .sts_q(sts_q)
  );

  hpr_rdmux #(.DW(DW), .FLD_W(FLD_W)) u_rdmux (
    .rsel(rsel), .plain_q(plain_q), .htba_q(htba_q), .sts_q(sts_q),
    .cfg_nwin(cfg_nwin), .cfg_maxtl(cfg_maxtl), .cfg_maxgl(cfg_maxgl),
    .rd_data(rd_data)
  );

  assign fault = flt;

  // R3: trap base never shows its cleared low bits
  p_htba_low_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && acc_idx == IDX_W'(R_HTBA)) |-> rd_data[LOWZ-1:0] == '0);

  // R4: trap-state access at trap level zero is illegal
  p_htst_tl0_r4: assert property (@(posedge clk) disable iff (rst)
    ((acc_rd || acc_wr) && acc_idx == IDX_W'(R_HTST) && trap_lvl == '0)
      |-> fault == 2'(FLT_ILLEGAL));

  // R5: version word is assembled from the configuration inputs
  p_version_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && acc_idx == IDX_W'(R_HVER))
      |-> rd_data == {{(DW-3*FLD_W){1'b0}}, cfg_maxgl, cfg_maxtl, cfg_nwin});

  // R6: status read returns last cycle's status input
  p_sts_read_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && acc_idx == IDX_W'(R_STS)) |-> rd_data == $past(sts_in));

  // R7: unknown index faults
  p_unknown_r7: assert property (@(posedge clk) disable iff (rst)
    ((acc_rd || acc_wr) && acc_idx >= IDX_W'(NREG)) |-> fault == 2'(FLT_ILLEGAL));

  // R8: no data escapes on a faulting or absent read
  p_zero_data_r8: assert property (@(posedge clk) disable iff (rst)
    (!acc_rd || fault != 2'(FLT_NONE)) |-> rd_data == '0);
endmodule

// File: tb/hpriv_ctl_regs_bench.sv
`timescale 1ns/1ps
module hpriv_ctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_rd = 1'b0;
  logic        acc_wr = 1'b0;
  logic [4:0]  acc_idx = '0;
  logic [63:0] acc_wdata = '0;
  logic [2:0]  trap_lvl = 3'd1;
  logic [7:0]  cfg_nwin = 8'd8;
  logic [7:0]  cfg_maxtl = 8'd6;
  logic [7:0]  cfg_maxgl = 8'd3;
  logic [63:0] sts_in = 64'h5A5A_0000_1234_00FF;
  logic [63:0] rd_data;
  logic [1:0]  fault;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  hpriv_ctl_regs u_hpriv_ctl_regs (
    .clk(clk), .rst(rst), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_idx(acc_idx),
    .acc_wdata(acc_wdata), .trap_lvl(trap_lvl), .cfg_nwin(cfg_nwin),
    .cfg_maxtl(cfg_maxtl), .cfg_maxgl(cfg_maxgl), .sts_in(sts_in),
    .rd_data(rd_data), .fault(fault)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  idx;
    logic [2:0]  tl;
    logic [63:0] wd;
    logic [1:0]  ef;
    logic [63:0] ed;
    logic [3:0]  rq;
  } vec_t;

  localparam logic [63:0] VA  = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] VB  = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] VC  = 64'h0000_00C0_FFEE_0001;
  localparam logic [63:0] ST0 = 64'h5A5A_0000_1234_00FF;
  localparam logic [63:0] TBM = 64'hFFFF_FFFF_FFFF_8000;

  localparam vec_t VECS [0:22] = '{
    '{1'b0, 5'd0,  3'd1, 64'd0, 2'd0, 64'd0,       4'd1}, // R1 cleared
    '{1'b0, 5'd3,  3'd1, 64'd0, 2'd0, 64'd0,       4'd1}, // R1 cleared
    '{1'b0, 5'd5,  3'd1, 64'd0, 2'd0, ST0,         4'd1}, // R1 status
    '{1'b1, 5'd0,  3'd1, VA,    2'd0, 64'd0,       4'd2}, // R2 write
    '{1'b0, 5'd0,  3'd1, 64'd0, 2'd0, VA,          4'd2}, // R2
    '{1'b1, 5'd1,  3'd1, VB,    2'd0, 64'd0,       4'd2}, // R2 write
    '{1'b0, 5'd1,  3'd1, 64'd0, 2'd0, VB,          4'd2}, // R2
    '{1'b0, 5'd0,  3'd1, 64'd0, 2'd0, VA,          4'd2}, // R2 hold
    '{1'b1, 5'd3,  3'd1, '1,    2'd0, 64'd0,       4'd3}, // R3 write
    '{1'b0, 5'd3,  3'd1, 64'd0, 2'd0, TBM,         4'd3}, // R3
    '{1'b1, 5'd2,  3'd1, VC,    2'd0, 64'd0,       4'd4}, // R4 write
    '{1'b0, 5'd2,  3'd1, 64'd0, 2'd0, VC,          4'd4}, // R4
    '{1'b0, 5'd2,  3'd0, 64'd0, 2'd1, 64'd0,       4'd4}, // R4 tl0 read
    '{1'b1, 5'd2,  3'd0, 64'd1, 2'd1, 64'd0,       4'd4}, // R4 tl0 write
    '{1'b0, 5'd2,  3'd3, 64'd0, 2'd0, VC,          4'd4}, // R4 unchanged
    '{1'b0, 5'd4,  3'd1, 64'd0, 2'd0, 64'h030608,  4'd5}, // R5
    '{1'b1, 5'd4,  3'd1, 64'd1, 2'd1, 64'd0,       4'd5}, // R5 write
    '{1'b1, 5'd5,  3'd1, 64'd0, 2'd0, 64'd0,       4'd6}, // R6 write
    '{1'b0, 5'd5,  3'd1, 64'd0, 2'd0, ST0,         4'd6}, // R6
    '{1'b0, 5'd6,  3'd1, 64'd0, 2'd1, 64'd0,       4'd7}, // R7 read
    '{1'b1, 5'd31, 3'd1, 64'd0, 2'd1, 64'd0,       4'd7}, // R7 write
    '{1'b0, 5'd0,  3'd1, 64'd0, 2'd0, VA,          4'd7}, // R7 no change
    '{1'b0, 5'd3,  3'd1, 64'd0, 2'd0, TBM,         4'd7}  // R7 no change
  };

  task automatic check(input string rq, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [4:0] idx, input logic [2:0] tl,
                        input logic [63:0] wd);
    @(negedge clk);
    acc_rd    = !wr;
    acc_wr    = wr;
    acc_idx   = idx;
    trap_lvl  = tl;
    acc_wdata = wd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_rd = 1'b0;
    acc_wr = 1'b0;
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i <= 22; i++) begin
      access(VECS[i].wr, VECS[i].idx, VECS[i].tl, VECS[i].wd);
      check($sformatf("R%0d fault v%0d", VECS[i].rq, i), 64'(fault), 64'(VECS[i].ef));
      check($sformatf("R%0d data v%0d", VECS[i].rq, i), rd_data, VECS[i].ed);
    end

    // R8: no strobe gives no fault and zero data
    idle();
    check("R8 idle fault", 64'(fault), 64'd0);
    check("R8 idle data", rd_data, 64'd0);

    // R5: version follows configuration inputs combinationally
    @(negedge clk);
    cfg_nwin = 8'hA1; cfg_maxtl = 8'hB2; cfg_maxgl = 8'hC3;
    access(1'b0, 5'd4, 3'd1, 64'd0);
    check("R5 new cfg", rd_data, 64'h0000_0000_00C3_B2A1);

    // R6: one-cycle lag on status input
    @(negedge clk);
    acc_rd = 1'b1; acc_idx = 5'd5;
    sts_in = 64'h1111_2222_3333_4444;
    #1;
    check("R6 old status", rd_data, ST0);
    @(negedge clk);
    #1;
    check("R6 new status", rd_data, 64'h1111_2222_3333_4444);

    // R3: a low-only write leaves a fully zero base
    access(1'b1, 5'd3, 3'd1, 64'h0000_0000_0000_7FFF);
    access(1'b0, 5'd3, 3'd1, 64'd0);
    check("R3 low only", rd_data, 64'd0);

    // R1: reset mid-run clears writable state, status reloads
    idle();
    @(negedge clk);
    rst = 1'b1;
    sts_in = 64'hDEAD_0000_BEEF_0001;
    @(negedge clk);
    rst = 1'b0;
    access(1'b0, 5'd0, 3'd1, 64'd0);
    check("R1 reset hpst", rd_data, 64'd0);
    access(1'b0, 5'd1, 3'd1, 64'd0);
    check("R1 reset hint", rd_data, 64'd0);
    access(1'b0, 5'd2, 3'd1, 64'd0);
    check("R1 reset htst", rd_data, 64'd0);
    access(1'b0, 5'd5, 3'd1, 64'd0);
    check("R1 reset status", rd_data, 64'hDEAD_0000_BEEF_0001);

    idle();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule